// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Master

This block is the host side of a three-wire serial link that drives a chain of quad DAC devices. The SCK, serial data and load strobe wires run through every device in series. Each device's serial output feeds the next device's input, and the last device's output returns to this block. Every device in the chain can take one command per transaction. The caller gives, for each device, an enable flag, a 4-bit command, a 4-bit channel address and a 16-bit data value. On one start pulse the block builds a 32-bit word for each device. It joins the words into a single frame and shifts the whole frame out inside one low period of the load strobe. It then raises the strobe once, so that every device acts on its word at the same moment.

Words are placed so that the device farthest from the master receives its word first. A device whose enable flag is low receives a no-operation word. The bits that come back from the end of the chain are captured into a readback register. With a chain of these devices, the readback register holds the frame that the previous transaction left in the chain. The SCK half period is a whole number of system clocks, set by a parameter. This lets the caller meet the device limits on clock rate, pulse width and setup time.

Top module: `dac_chain_master`

## Requirements
- R1: While reset is held and after it is released, load_n is high, sck is low, ser_out is low, busy is low and done is low.
- R2: Each device word is 32 bits, sent MSB first: 8 filler bits of value 0, then the 4-bit command, then the 4-bit address, then the 16-bit data.
- R3: Device index N_DEV-1 is the device farthest along the chain. Its word is shifted first and device 0's word is shifted last. After the frame, the 32 bits held by the device at position i are exactly the word built for dev_*[i].
- R4: A device whose dev_en bit is 0 receives the no-operation word: command 1111, address 1111 and data 0.
- R5: load_n falls on the clock edge that accepts start. It stays low for exactly 32*N_DEV rising sck edges and rises only once per transaction.
- R6: Each sck high phase and each sck low phase lasts HALF_CYC system clocks. The first sck rise comes HALF_CYC clocks after load_n falls. load_n rises HALF_CYC clocks after the final sck fall. sck is low whenever load_n is high.
- R7: ser_out changes only when sck falls or when load_n changes, so ser_out is stable for the whole of each sck high phase.
- R8: chain_ret is sampled on each sck rise into readback, shifting toward the MSB, so the first returned bit ends in readback[32*N_DEV-1]. readback keeps its value between transactions.
- R9: done is high for exactly one system clock: the first cycle in which load_n reads high again.
- R10: busy is high from the cycle after start is accepted until HALF_CYC clocks after load_n rises. A start pulse while busy is high is ignored, along with any change on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transaction; accepted only while busy is low |
| dev_en | input | N_DEV | Per-device enable; 0 sends a no-operation word |
| dev_cmd | input | 4*N_DEV | Per-device command, device i at bits [4i+3:4i] |
| dev_addr | input | 4*N_DEV | Per-device channel address, device i at bits [4i+3:4i] |
| dev_data | input | 16*N_DEV | Per-device data, device i at bits [16i+15:16i] |
| chain_ret | input | 1 | Serial output returning from the last device |
| sck | output | 1 | Serial clock to the chain |
| ser_out | output | 1 | Serial data into the first device |
| load_n | output | 1 | Chip-select and load strobe, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when load_n returns high |
| readback | output | 32*N_DEV | Bits captured from chain_ret |

## Verification
The bench builds the block with N_DEV = 3 and HALF_CYC = 3. This gives a 96-bit frame in which the middle device can be disabled while the devices on both sides stay active, so a misplaced word or a wrong no-operation fill cannot hide at either end of the frame. With three system clocks per phase, the leading gap, the trailing gap and the recovery gap are each several cycles long, so an off-by-one in any phase length shows up. A behavioural three-device chain in the bench returns the previous frame, which makes the readback content predictable from one transaction to the next.

// File: rtl/dcm_pkg.sv
// Package: shared widths, codes and sequencer states for the daisy-chain DAC master.
// Assumes every device in the chain uses the same 32-bit word format.
package dcm_pkg;
    localparam int FILL_W = 8;
    localparam int CMD_W  = 4;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int WORD_W = FILL_W + CMD_W + ADDR_W + DATA_W;

    localparam logic [CMD_W-1:0]  NOP_CMD  = 4'b1111;
    localparam logic [ADDR_W-1:0] NOP_ADDR = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_RECOV
    } seq_state_t;
endpackage

// File: rtl/dcm_frame_pack.sv
// Frame packer: builds one 32-bit word per device and places device N_DEV-1 in
// the most significant word, so that it is shifted out first.
// Assumes the requests are held stable while the sequencer captures the frame.
module dcm_frame_pack
    import dcm_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int TOT_W = WORD_W * N_DEV
) (
    input  logic [N_DEV-1:0]        dev_en,
    input  logic [CMD_W*N_DEV-1:0]  dev_cmd,
    input  logic [ADDR_W*N_DEV-1:0] dev_addr,
    input  logic [DATA_W*N_DEV-1:0] dev_data,
    output logic [TOT_W-1:0]        frame
);
    for (genvar i = 0; i < N_DEV; i++) begin : g_word
        // Per-device word: the requested command, or a no-operation filler.
        always_comb begin
            if (dev_en[i])
                frame[WORD_W*i +: WORD_W] = {{FILL_W{1'b0}},
                                             dev_cmd[CMD_W*i +: CMD_W],
                                             dev_addr[ADDR_W*i +: ADDR_W],
                                             dev_data[DATA_W*i +: DATA_W]};
            else
                frame[WORD_W*i +: WORD_W] = {{FILL_W{1'b0}}, NOP_CMD, NOP_ADDR,
                                             {DATA_W{1'b0}}};
        end
    end
endmodule

// File: rtl/dcm_half_timer.sv
// Half-period timer: while run is high, it pulses expire once every HALF_CYC
// clocks. Its count returns to zero whenever run is low.
// Assumes HALF_CYC >= 1.
module dcm_half_timer #(
    parameter int HALF_CYC = 3,
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(HALF_CYC - 1));

    // Count system clocks within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HALF_CYC - 1)); // R6
endmodule

// File: rtl/dcm_sequencer.sv
// Sequencer: captures the frame on start, drives load_n, sck and ser_out one
// phase at a time, and samples the return bit on each sck rise.
// Assumes expire comes from a timer that runs while busy is high.
module dcm_sequencer
    import dcm_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int TOT_W = WORD_W * N_DEV,
    localparam int BW    = $clog2(TOT_W),
    localparam int EW    = $clog2(TOT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOT_W-1:0] frame,
    input  logic             chain_ret,
    input  logic             expire,
    output logic             run,
    output logic             sck,
    output logic             ser_out,
    output logic             load_n,
    output logic             busy,
    output logic             done,
    output logic [TOT_W-1:0] readback
);
    seq_state_t       state;
    logic [TOT_W-1:0] sh;
    logic [BW-1:0]    bit_idx;
    logic             sck_q, load_n_q, done_q;
    logic [TOT_W-1:0] rb;

    assign run      = (state != ST_IDLE);
    assign busy     = run;
    assign sck      = sck_q;
    assign ser_out  = sh[TOT_W-1];
    assign load_n   = load_n_q;
    assign done     = done_q;
    assign readback = rb;

    // Phase machine: move to the next phase on each timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sh       <= '0;
            bit_idx  <= '0;
            sck_q    <= 1'b0;
            load_n_q <= 1'b1;
            done_q   <= 1'b0;
            rb       <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    sh       <= frame;
                    bit_idx  <= '0;
                    load_n_q <= 1'b0;
                    state    <= ST_LEAD;
                end
                ST_LEAD, ST_LOW: if (expire) begin
                    sck_q <= 1'b1;
                    rb    <= {rb[TOT_W-2:0], chain_ret};
                    state <= ST_HIGH;
                end
                ST_HIGH: if (expire) begin
                    sck_q <= 1'b0;
                    if (bit_idx == BW'(TOT_W - 1)) begin
                        state <= ST_TAIL;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sh      <= {sh[TOT_W-2:0], 1'b0};
                        state   <= ST_LOW;
                    end
                end
                ST_TAIL: if (expire) begin
                    load_n_q <= 1'b1;
                    sh       <= '0;
                    done_q   <= 1'b1;
                    state    <= ST_RECOV;
                end
                ST_RECOV: if (expire) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker state: count sck rises inside one load window.
    logic          sck_d;
    logic [EW-1:0] edge_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            edge_cnt <= '0;
        end else begin
            sck_d <= sck_q;
            if (state == ST_IDLE && start)
                edge_cnt <= '0;
            else if (sck_q && !sck_d)
                edge_cnt <= edge_cnt + 1'b1;
        end
    end

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_n_q) |-> (edge_cnt == EW'(TOT_W))); // R5
    AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q != $past(sck_q)) |-> $past(expire)); // R6
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_n_q |-> !sck_q); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(ser_out)); // R7
    AST_DONE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $rose(load_n_q)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R9
endmodule

// File: rtl/dac_chain_master.sv
// Top: host master for a daisy chain of N_DEV quad DACs. Each start pulse
// sends one frame of 32*N_DEV bits within a single load window.
// Assumes HALF_CYC system clocks cover the minimum SCK high and low times.
module dac_chain_master
    import dcm_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int HALF_CYC = 3,
    localparam int TOT_W = WORD_W * N_DEV
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_DEV-1:0]        dev_en,
    input  logic [CMD_W*N_DEV-1:0]  dev_cmd,
    input  logic [ADDR_W*N_DEV-1:0] dev_addr,
    input  logic [DATA_W*N_DEV-1:0] dev_data,
    input  logic                    chain_ret,
    output logic                    sck,
    output logic                    ser_out,
    output logic                    load_n,
    output logic                    busy,
    output logic                    done,
    output logic [TOT_W-1:0]        readback
);
    logic [TOT_W-1:0] frame;
    logic             run, expire;

    dcm_frame_pack #(.N_DEV(N_DEV)) u_pack (
        .dev_en  (dev_en),
        .dev_cmd (dev_cmd),
        .dev_addr(dev_addr),
        .dev_data(dev_data),
        .frame   (frame)
    );

    dcm_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .expire(expire)
    );

    dcm_sequencer #(.N_DEV(N_DEV)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .chain_ret(chain_ret),
        .expire   (expire),
        .run      (run),
        .sck      (sck),
        .ser_out  (ser_out),
        .load_n   (load_n),
        .busy     (busy),
        .done     (done),
        .readback (readback)
    );
endmodule

// File: tb/tb_dac_chain_master.sv
// Bench: behavioural reference queue of expected per-cycle outputs, compared on
// every falling clock edge, plus a behavioural device chain on the serial pins.
module tb_dac_chain_master;
    localparam int N   = 3;
    localparam int H   = 3;
    localparam int TOT = 32 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0]    en = '0;
    logic [4*N-1:0]  cmd = '0;
    logic [4*N-1:0]  addr = '0;
    logic [16*N-1:0] data = '0;
    logic chain_ret = 1'b0;
    logic sck, ser_out, load_n, busy, done;
    logic [TOT-1:0] readback;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [4:0] expq[$];          // {busy, load_n, sck, ser_out, done}
    logic [TOT-1:0] chain_sr = '0;
    logic [TOT-1:0] last_frame = '0;

    always #2 clk = ~clk;

    dac_chain_master #(.N_DEV(N), .HALF_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_en(en), .dev_cmd(cmd),
        .dev_addr(addr), .dev_data(data), .chain_ret(chain_ret), .sck(sck),
        .ser_out(ser_out), .load_n(load_n), .busy(busy), .done(done),
        .readback(readback)
    );

    // Device chain model: shift on sck rise, present the oldest bit on sck fall.
    always @(posedge sck) chain_sr <= {chain_sr[TOT-2:0], ser_out};
    always @(negedge sck) chain_ret <= chain_sr[TOT-1];

    task automatic chk(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: compare outputs against the reference at the falling edge.
    task automatic step();
        logic [4:0] e;
        @(negedge clk);
        e = (expq.size() > 0) ? expq.pop_front() : 5'b01000;
        chk("R10 busy",    TOT'(busy),    TOT'(e[4]));
        chk("R5 load_n",   TOT'(load_n),  TOT'(e[3]));
        chk("R6 sck",      TOT'(sck),     TOT'(e[2]));
        chk("R7 ser_out",  TOT'(ser_out), TOT'(e[1]));
        chk("R9 done",     TOT'(done),    TOT'(e[0]));
    endtask

    function automatic logic [TOT-1:0] build(input logic [N-1:0] e, input logic [4*N-1:0] c,
                                             input logic [4*N-1:0] a, input logic [16*N-1:0] d);
        logic [TOT-1:0] f;
        for (int i = 0; i < N; i++)
            f[32*i +: 32] = e[i] ? {8'h00, c[4*i +: 4], a[4*i +: 4], d[16*i +: 16]}
                                 : {8'h00, 4'hF, 4'hF, 16'h0000};
        return f;
    endfunction

    task automatic push_frame(input logic [TOT-1:0] f);
        for (int c = 0; c < H; c++) expq.push_back({1'b1, 1'b0, 1'b0, f[TOT-1], 1'b0});
        for (int b = 0; b < TOT; b++) begin
            for (int c = 0; c < H; c++) expq.push_back({1'b1, 1'b0, 1'b1, f[TOT-1-b], 1'b0});
            if (b < TOT - 1)
                for (int c = 0; c < H; c++) expq.push_back({1'b1, 1'b0, 1'b0, f[TOT-2-b], 1'b0});
        end
        for (int c = 0; c < H; c++) expq.push_back({1'b1, 1'b0, 1'b0, f[0], 1'b0});
        for (int c = 0; c < H; c++) expq.push_back({1'b1, 1'b1, 1'b0, 1'b0, (c == 0)});
    endtask

    task automatic run_frame(input logic [N-1:0] e, input logic [4*N-1:0] c,
                             input logic [4*N-1:0] a, input logic [16*N-1:0] d, input bit poke);
        logic [TOT-1:0] f;
        logic [TOT-1:0] prev;
        f = build(e, c, a, d);
        prev = last_frame;
        en = e; cmd = c; addr = a; data = d; start = 1'b1;
        push_frame(f);
        step();
        start = 1'b0;
        for (int k = 0; expq.size() > 0; k++) begin
            step();
            if (poke && k == 100) begin   // R10: start while busy, with other requests
                start = 1'b1; en = ~e; cmd = ~c; addr = ~a; data = ~d;
            end else if (poke && k == 101) begin
                start = 1'b0;
            end
        end
        step();
        for (int i = 0; i < N; i++) begin
            chk("R2 filler", TOT'(chain_sr[32*i+24 +: 8]), '0);
            if (e[i]) begin
                chk("R3 command", TOT'(chain_sr[32*i+20 +: 4]), TOT'(c[4*i +: 4]));
                chk("R3 address", TOT'(chain_sr[32*i+16 +: 4]), TOT'(a[4*i +: 4]));
                chk("R3 data",    TOT'(chain_sr[32*i +: 16]),   TOT'(d[16*i +: 16]));
            end else begin
                chk("R4 nop command", TOT'(chain_sr[32*i+20 +: 4]), TOT'(4'hF));
                chk("R4 nop address", TOT'(chain_sr[32*i+16 +: 4]), TOT'(4'hF));
                chk("R4 nop data",    TOT'(chain_sr[32*i +: 16]),   '0);
            end
        end
        chk("R8 readback", readback, prev);
        last_frame = f;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 load_n",  TOT'(load_n),  TOT'(1'b1));
        chk("R1 sck",     TOT'(sck),     '0);
        chk("R1 ser_out", TOT'(ser_out), '0);
        chk("R1 busy",    TOT'(busy),    '0);
        chk("R1 done",    TOT'(done),    '0);
        chk("R8 readback reset", readback, '0);
        rst_n = 1'b1;
        repeat (4) step();
        run_frame(3'b111, 12'h3A5, 12'h102, 48'hBEEF_1234_0FF0, 1'b0);
        repeat (2) step();
        run_frame(3'b101, 12'h8C1, 12'h7F0, 48'h8001_5555_FFFF, 1'b1);
        run_frame(3'b000, 12'h123, 12'h456, 48'hAAAA_BBBB_CCCC, 1'b0);
        run_frame(3'b010, 12'h020, 12'h030, 48'h0000_7FFF_0000, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule